// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Engine

A synchronous single-port memory that accepts a command on every enabled clock edge. Reads and writes can be mixed in any order with no idle cycle between them. A read is registered on one edge. Its data is captured in an output register on the next enabled edge and is presented after that edge. A write is registered together with its per-byte enables, and the matching data word is taken from the data input two enabled edges later. Because the write data arrives at the same depth in the pipe as read data leaves it, the shared data bus never needs a turnaround slot.

A command is issued by pulling the load strobe low with all three selects active. With the load strobe high, the previous operation type continues as a burst. In that case the word address comes from an external burst counter through a separate input. An active-high clock-enable-bar freezes every register, including the in-flight stages. An asynchronous output-enable-bar gates only the drive indication. A read that meets a write still in the pipe returns the byte-merged new data. The array is built from per-lane memories so that block RAM can be inferred.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted on an edge only when `cke_n`=0, `adv`=0 and the selects read `cs1_n`=0, `cs2`=1, `cs2_n`=0. With `adv`=0 and any select inactive, the edge is a deselect: nothing is written and no read data is produced.
- R2: For a read accepted on edge N, the word at its address is presented on `dout` with `dout_en`=1 after enabled edge N+1, and it stays until the next enabled edge.
- R3: For a write accepted on edge N, the data is sampled from `din` on enabled edge N+2. The value of `din` on any other edge is ignored.
- R4: `bw_n[i]`=0 at the write command edge enables byte lane i (bits 8i+7:8i). If all `bw_n` bits are 1, the write is an abort and leaves the memory unchanged.
- R5: With `adv`=1 after an accepted read or write, a further operation of the same type is issued at `burst_addr`. A continued write takes its lane enables from `bw_n` on that edge. With `adv`=1 after a deselect, the edge is a continued deselect and nothing is issued.
- R6: While `cke_n`=1, all synchronous inputs are ignored and every register holds, including the pending pipeline stages and `dout`.
- R7: `dout_en` is 0 whenever `oe_n`=1, without regard to the pipeline state. A read issued while `oe_n`=1 still advances the pipe.
- R8: A read whose data is captured on the same edge that completes a write to the same address returns the write's byte-merged data, not the stale array word.
- R9: Synchronous reset clears all pipeline valid state. After reset `dout_en`=0, and a write pending at reset never reaches the memory.
- R10: Back-to-back commands of any mix, alternating read and write included, complete with no idle cycle and with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; 1 freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new command, 1 = continue burst |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | NB | Per-byte write enables, active low |
| addr | input | AW | Word address for a new command |
| burst_addr | input | AW | Next address from the external burst counter |
| din | input | NB*LW | Write data, sampled two edges after its command |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dout | output | NB*LW | Registered read data |
| dout_en | output | 1 | Output drive indication |

## Verification
A stage that fails to hold during a clock-enable stall, or that shifts on a stalled edge, moves read data to the wrong cycle. That shows up as `dout_en` rising one cycle early or late, or as a write landing with the wrong `din` word; the fault appears at the ports on the very next read of the touched address. A lost or wrong forwarding path shows as stale bytes on `dout` one enabled edge after the read command. Burst state that fails to clear on a deselect causes a spurious write, which is caught on the next read of that address. The bench checks `dout_en` and `dout` against the model on every cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // Type of the last accepted command, used for burst continuation
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_decode.sv
module zt_sram_decode
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          adv,
  input  logic          sel,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] burst_addr,
  output logic          cmd_vld,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_addr,
  output logic [NB-1:0] cmd_mask
);

  op_e last_q, last_d;

  always_comb begin
    cmd_vld  = 1'b0;
    cmd_wr   = 1'b0;
    cmd_addr = addr;
    last_d   = last_q;
    if (!adv) begin
      if (sel) begin
        cmd_vld = 1'b1;
        cmd_wr  = !we_n;
        last_d  = we_n ? OP_READ : OP_WRITE;
      end else begin
        last_d  = OP_IDLE;
      end
    end else if (last_q != OP_IDLE) begin
      cmd_vld  = 1'b1;
      cmd_wr   = (last_q == OP_WRITE);
      cmd_addr = burst_addr;
    end
    cmd_mask = cmd_wr ? ~bw_n : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)     last_q <= OP_IDLE;
    else if (ce) last_q <= last_d;
  end

  // R5: continuing after a deselect issues nothing
  assert_cont_desel_R5: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv && !sel) |=> !(adv && cmd_vld));

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          cmd_vld,
  input  logic          cmd_wr,
  input  logic [AW-1:0] cmd_addr,
  input  logic [NB-1:0] cmd_mask,
  output logic          s1_busy,
  output logic          rd_vld,
  output logic [AW-1:0] rd_addr,
  output logic          wr_vld,
  output logic [AW-1:0] wr_addr,
  output logic [NB-1:0] wr_mask
);

  logic          v1_q, w1_q, v2_q;
  logic [AW-1:0] a1_q, a2_q;
  logic [NB-1:0] m1_q, m2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (ce) begin
      v1_q <= cmd_vld;
      v2_q <= v1_q && w1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      w1_q <= cmd_wr;
      a1_q <= cmd_addr;
      m1_q <= cmd_mask;
      a2_q <= a1_q;
      m2_q <= m1_q;
    end
  end

  assign s1_busy = v1_q;
  assign rd_vld  = v1_q && !w1_q;
  assign rd_addr = a1_q;
  assign wr_vld  = v2_q;
  assign wr_addr = a2_q;
  assign wr_mask = m2_q;

  // R3: a write in stage one reaches the data-sampling stage on the next enabled edge
  assert_wr_depth_R3: assert property (@(posedge clk) disable iff (rst)
    (ce && v1_q && w1_q) |=> wr_vld);

  // R6: stalled edges move nothing
  assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(v1_q) && $stable(v2_q) && $stable(a1_q) && $stable(a2_q)));

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NB-1:0]    wr_mask,
  input  logic [NB*LW-1:0] wdata,
  output logic [NB*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic same_addr;
  assign same_addr = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;

    always_ff @(posedge clk) begin
      if (ce) begin
        if (wr_en && wr_mask[g])
          mem[wr_addr] <= wdata[g*LW +: LW];
        if (rd_en)
          q <= (same_addr && wr_mask[g]) ? wdata[g*LW +: LW] : mem[rd_addr];
      end
    end

    assign rdata[g*LW +: LW] = q;
  end

  // R8: a full-word write completing under a read of the same word is returned
  assert_bypass_R8: assert property (@(posedge clk)
    (ce && rd_en && same_addr && (wr_mask == {NB{1'b1}})) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs2_n,
  input  logic             adv,
  input  logic             we_n,
  input  logic [NB-1:0]    bw_n,
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    burst_addr,
  input  logic [NB*LW-1:0] din,
  input  logic             oe_n,
  output logic [NB*LW-1:0] dout,
  output logic             dout_en
);

  localparam int DW = NB * LW;

  logic          ce, sel;
  logic          cmd_vld, cmd_wr;
  logic [AW-1:0] cmd_addr;
  logic [NB-1:0] cmd_mask;
  logic          s1_busy, rd_vld, wr_vld;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [NB-1:0] wr_mask;
  logic [DW-1:0] rdata;
  logic          out_vld_q;

  assign ce  = !cke_n;
  assign sel = !cs1_n && cs2 && !cs2_n;

  zt_sram_decode #(.AW(AW), .NB(NB)) u_decode (
    .clk(clk), .rst(rst), .ce(ce), .adv(adv), .sel(sel), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .burst_addr(burst_addr),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_mask(cmd_mask)
  );

  zt_sram_pipe #(.AW(AW), .NB(NB)) u_pipe (
    .clk(clk), .rst(rst), .ce(ce),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_mask(cmd_mask),
    .s1_busy(s1_busy), .rd_vld(rd_vld), .rd_addr(rd_addr),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_mask(wr_mask)
  );

  zt_sram_array #(.AW(AW), .NB(NB), .LW(LW)) u_array (
    .clk(clk), .ce(ce), .rd_en(rd_vld), .rd_addr(rd_addr),
    .wr_en(wr_vld), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .wdata(din), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)     out_vld_q <= 1'b0;
    else if (ce) out_vld_q <= rd_vld;
  end

  assign dout    = rdata;
  assign dout_en = out_vld_q && !oe_n;

  // R1: a deselect edge leaves the first stage empty
  assert_desel_empty_R1: assert property (@(posedge clk) disable iff (rst)
    (ce && !adv && !sel) |=> !s1_busy);

  // R2: a read in stage one produces valid output after the next enabled edge
  assert_read_lat_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && rd_vld) |=> out_vld_q);

  // R6: output register holds while stalled
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(dout) && $stable(out_vld_q)));

  // R9: reset leaves no valid read output and no pending write
  assert_reset_clear_R9: assert property (@(posedge clk)
    $past(rst) |-> (!out_vld_q && !wr_vld));

endmodule

// File: tb/zt_sram_tb.sv
module zt_sram_tb;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int LW = 8;
  localparam int DW = NB * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke_n = 1'b0, cs1_n = 1'b1, cs2 = 1'b0, cs2_n = 1'b1;
  logic          adv = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0, burst_addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #2.5 clk = ~clk;

  zt_sram #(.AW(AW), .NB(NB), .LW(LW)) u_dut (
    .clk(clk), .rst(rst), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs2_n(cs2_n),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr), .burst_addr(burst_addr),
    .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  // ---------------- reference model ----------------
  typedef struct {
    bit          wr;
    int          ad;
    bit [NB-1:0] msk;
    logic [DW-1:0] dat;
    int          age;
  } op_t;

  op_t           ops[$];
  logic [DW-1:0] mmem [1 << AW];
  logic [DW-1:0] exp_data;
  bit            exp_vld = 0;
  int            last_op = 0; // 0 idle, 1 read, 2 write
  int            checks = 0, errors = 0;
  string         tag = "R9";

  task automatic compare();
    bit exp_en;
    exp_en = exp_vld && !oe_n;
    checks++;
    if (dout_en !== exp_en) begin
      errors++;
      $display("FAIL %s dout_en actual=%b expected=%b at %0t", tag, dout_en, exp_en, $time);
    end else if (exp_en && !$isunknown(exp_data) && dout !== exp_data) begin
      errors++;
      $display("FAIL %s dout actual=%h expected=%h at %0t", tag, dout, exp_data, $time);
    end
  endtask

  // One clock: check outputs of the previous edge, drive inputs, advance the model
  task automatic go(input bit ck_n, input bit a_dv, input bit [2:0] cs, input bit w_n,
                    input bit [NB-1:0] b_n, input int ad, input int bad,
                    input logic [DW-1:0] d, input bit o_n);
    op_t nq[$];
    op_t no;
    bit  sl;
    @(negedge clk);
    compare();
    cke_n = ck_n; adv = a_dv; {cs1_n, cs2, cs2_n} = cs; we_n = w_n; bw_n = b_n;
    addr = AW'(ad); burst_addr = AW'(bad); oe_n = o_n;
    din = {$urandom, $urandom};
    if (!ck_n) begin
      foreach (ops[i]) ops[i].age++;
      foreach (ops[i]) if (ops[i].wr && ops[i].age == 2) begin
        din = ops[i].dat;
        for (int b = 0; b < NB; b++)
          if (ops[i].msk[b]) mmem[ops[i].ad][b*LW +: LW] = ops[i].dat[b*LW +: LW];
      end
      exp_vld = 0;
      foreach (ops[i]) if (!ops[i].wr && ops[i].age == 1) begin
        exp_vld  = 1;
        exp_data = mmem[ops[i].ad];
      end
      foreach (ops[i])
        if (!((ops[i].wr && ops[i].age >= 2) || (!ops[i].wr && ops[i].age >= 1)))
          nq.push_back(ops[i]);
      ops = nq;
      sl = (cs == 3'b010);
      if (!a_dv) begin
        if (sl) begin
          no.wr = !w_n; no.ad = ad; no.msk = w_n ? '0 : ~b_n; no.dat = d; no.age = 0;
          ops.push_back(no);
          last_op = w_n ? 1 : 2;
        end else last_op = 0;
      end else if (last_op != 0) begin
        no.wr = (last_op == 2); no.ad = bad; no.msk = no.wr ? ~b_n : '0;
        no.dat = d; no.age = 0;
        ops.push_back(no);
      end
    end
  endtask

  task automatic wr(input int ad, input logic [DW-1:0] d, input bit [NB-1:0] b_n = '0);
    go(0, 0, 3'b010, 0, b_n, ad, 0, d, 0);
  endtask
  task automatic rd(input int ad, input bit o_n = 0);
    go(0, 0, 3'b010, 1, '1, ad, 0, '0, o_n);
  endtask
  task automatic cont(input int bad, input logic [DW-1:0] d, input bit [NB-1:0] b_n = '0);
    go(0, 1, 3'b010, 0, b_n, 0, bad, d, 0);
  endtask
  task automatic idle(input bit o_n = 0);
    go(0, 0, 3'b110, 1, '1, 0, 0, '0, o_n);
  endtask
  task automatic stall(input int ad);
    go(1, 0, 3'b010, 0, '0, ad, ad, 32'hDEAD_BEEF, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < (1 << AW); i++) mmem[i] = 'x;
    repeat (3) @(negedge clk);
    rst = 0; cs1_n = 1;

    // R9: reset state
    tag = "R9"; idle(); idle();

    // R10: back-to-back writes, then alternating read/write
    tag = "R10";
    for (int i = 0; i < 32; i++) wr(i, {8'(i), 8'(i ^ 8'h5A), 8'(~i), 8'(i * 3)});
    for (int i = 0; i < 16; i++) begin
      rd(i);
      wr(32 + i, {$urandom});
    end
    for (int i = 32; i < 48; i++) rd(i);
    idle(); idle();

    // R1: every inactive select combination blocks a write
    tag = "R1";
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) go(0, 0, 3'(c), 0, '0, 3, 0, 32'hBAD0_0000 + c, 0);
    end
    idle(); rd(3); go(0, 0, 3'b000, 1, '1, 3, 0, '0, 0); idle(); idle();

    // R4: byte lanes and write abort
    tag = "R4";
    wr(5, 32'hA1B2_C3D4, 4'b1010);
    wr(6, 32'h1111_2222, 4'b1111);
    wr(7, 32'h7777_8888, 4'b0110);
    idle(); rd(5); rd(6); rd(7); idle(); idle();

    // R5: write burst, read burst, continued deselect
    tag = "R5";
    wr(8, 32'h0808_0808);
    cont(9, 32'h0909_0909);
    cont(10, 32'h1010_1010, 4'b0011);
    cont(11, 32'h1111_1111);
    rd(8); go(0, 1, 3'b010, 1, '1, 0, 9, '0, 0);
    go(0, 1, 3'b010, 1, '1, 0, 10, '0, 0);
    go(0, 1, 3'b010, 1, '1, 0, 11, '0, 0);
    idle();
    go(0, 1, 3'b010, 0, '0, 0, 9, 32'hFFFF_0000, 0);
    go(0, 1, 3'b010, 0, '0, 0, 9, 32'hFFFF_0000, 0);
    idle(); rd(9); idle(); idle();

    // R6: stalls freeze reads and writes in flight
    tag = "R6";
    rd(2); stall(2); stall(2); stall(4); idle(); idle();
    wr(12, 32'hC0DE_1234); stall(12); idle(); stall(12); stall(12); idle();
    rd(12); stall(0); stall(0); idle(); idle();

    // R7: output enable gates drive only
    tag = "R7";
    rd(13, 1); idle(1); idle(0);
    rd(14); idle(1); idle(0); idle(); idle();

    // R8: read right after write to same address, full and partial
    tag = "R8";
    wr(20, 32'h2020_ABCD); rd(20);
    wr(21, 32'hFEED_0000, 4'b1100); rd(21);
    wr(22, 32'h3333_4444); idle(); rd(22);
    idle(); idle();

    // R2: isolated read latency
    tag = "R2";
    rd(1); idle(); idle(); rd(31); idle(); idle();

    // R3: write with junk around its data slot
    tag = "R3";
    wr(40, 32'h4040_4040); idle(); idle(); idle(); rd(40); idle(); idle();

    // R9: reset drops a pending write and a pending read
    tag = "R9";
    rd(25); wr(30, 32'hAAAA_5555);
    @(negedge clk); compare();
    rst = 1; cke_n = 0; adv = 0; {cs1_n, cs2, cs2_n} = 3'b110;
    ops.delete(); exp_vld = 0; last_op = 0;
    @(negedge clk); compare();
    rst = 0;
    idle(); idle(); rd(30); idle(); idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule